// File: doc/BRIEF.md
# Audio Master Clock Ratio Detector

This block measures how many system clock cycles make up one period of the audio word clock (the sample-rate clock). It then maps that count onto one of six supported oversampling ratios: 128, 192, 256, 384, 512 or 768 times the sample rate. A downstream digital filter and modulator uses the result to pick its clocking scheme. The word clock arrives asynchronously. It passes through a two-flop synchroniser, and each rising edge after synchronisation closes one measurement window and opens the next.

The count must lie within a small tolerance of a supported ratio. The ratio must also be legal for the selected sample-rate class and for the modulator oversampling mode. A window is accepted only when both hold. Two accepted windows in a row with the same classification lock the detector. Any window that is rejected, that differs from the previous one, or that never ends drops the lock. After power-on or an external reset, the detector holds its outputs in their default state for 1024 system clocks before it starts measuring.

The controller is a five-state machine:
- `ST_INIT`: the initialisation hold. It moves to `ST_WAIT` when the hold counter expires.
- `ST_WAIT`: waits for a first edge. An edge moves it to `ST_MEAS`.
- `ST_MEAS`: a window with no candidate. An accepted window moves it to `ST_CONFIRM`. A rejected window keeps it in `ST_MEAS`.
- `ST_CONFIRM`: holds a candidate. A matching accepted window moves it to `ST_LOCK`. A different accepted window stays in `ST_CONFIRM` with a new candidate. A rejected window goes back to `ST_MEAS`.
- `ST_LOCK`: locked. A matching window stays in `ST_LOCK`. A different accepted window goes to `ST_CONFIRM`. A rejected window goes to `ST_MEAS`.

From `ST_MEAS`, `ST_CONFIRM` or `ST_LOCK`, a timeout moves the machine to `ST_WAIT`.

Top module: `mclk_ratio_detect`

## Requirements
- R1: When locked, `ratio_o` gives 0, 1, 2, 3, 4 or 5 for a measured period of 128, 192, 256, 384, 512 or 768 system clocks respectively, with a tolerance of plus or minus 2 cycles.
- R2: `ratio_o` is 7 whenever `valid_o` is low, and the code 6 never appears.
- R3: A window count more than 2 cycles away from every supported ratio is rejected. `valid_o` goes low and `err_o` goes high.
- R4: For `rate_class_i` = 1 (96 kHz) and `rate_class_i` = 2 or 3 (192 kHz), the ratios 512 and 768 (codes 4 and 5) are rejected with `err_o` high. Ratios 128 to 384 are accepted. For `rate_class_i` = 0, all six ratios are accepted.
- R5: With `os128_i` high, the ratios 128, 192 and 256 (codes 0 to 2) are rejected with `err_o` high, so only ratios above 256 can lock.
- R6: `valid_o` rises only after two consecutive accepted windows give the same code.
- R7: When locked, a window that gives a different code drops `valid_o` at the end of that window.
- R8: If no rising word clock edge arrives within 1024 system clocks, `valid_o` goes low and `err_o` goes high.
- R9: For 1024 system clocks after `rst_ni` is released, the outputs stay at `ratio_o` = 7, `valid_o` = 0 and `err_o` = 0, whatever the word clock does.
- R10: Asserting `rst_ni` at any time returns the outputs to their default state and restarts the 1024-cycle hold.
- R11: An accepted window clears `err_o`, and `valid_o` and `err_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System (master) clock |
| rst_ni | input | 1 | Asynchronous active-low reset, power-on or external |
| wclk_i | input | 1 | Word clock, asynchronous to clk_i |
| rate_class_i | input | 2 | Sample-rate class: 0 up to 48 kHz, 1 96 kHz, 2 or 3 192 kHz |
| os128_i | input | 1 | High when the modulator runs at 128x oversampling |
| ratio_o | output | 3 | Ratio code 0 to 5, or 7 when not locked |
| valid_o | output | 1 | Locked: two matching accepted windows |
| err_o | output | 1 | Last window rejected or word clock missing |

## Verification
The assertions assume three things about the inputs. Each word clock phase is long enough for the synchroniser to see it. `rate_class_i` and `os128_i` settle at least one cycle before the window edge that checks them. Reset is the only way back to the hold. The stimulus uses word clock periods of 125 to 771 cycles, so every phase lasts dozens of cycles. It changes the period only at word clock cycle boundaries, and it gives every new setting enough windows to settle before it samples. The illegal combinations, the tolerance limits, the missing clock and a reset in mid-lock are each driven directly.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

    localparam int NUM_RATIOS = 6;
    localparam int CODE_W     = 3;
    localparam logic [CODE_W-1:0] CODE_NONE   = 3'd7;
    localparam logic [CODE_W-1:0] CODE_FIRST_HIGH = 3'd4; // 512x and above
    localparam logic [CODE_W-1:0] CODE_LAST_LOW   = 3'd2; // 256x and below

    typedef enum logic [2:0] {
        ST_INIT,
        ST_WAIT,
        ST_MEAS,
        ST_CONFIRM,
        ST_LOCK
    } det_state_e;

    function automatic int ratio_of(input int idx);
        case (idx)
            0:       return 128;
            1:       return 192;
            2:       return 256;
            3:       return 384;
            4:       return 512;
            default: return 768;
        endcase
    endfunction

endpackage

// File: rtl/mrd_edge_sync.sv
module mrd_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);
    logic [SYNC_STAGES:0] pipe_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[SYNC_STAGES-1:0], async_i};
    end

    assign rise_o = pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];
endmodule

// File: rtl/mrd_period_counter.sv
module mrd_period_counter #(
    parameter int TIMEOUT = 1024,
    parameter int CNT_W   = $clog2(TIMEOUT + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             edge_i,
    output logic [CNT_W-1:0] count_o,
    output logic             timeout_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT - 1);

    logic [CNT_W-1:0] cnt_q;

    assign count_o   = cnt_q;
    assign timeout_o = run_i && !edge_i && (cnt_q == LIMIT);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        cnt_q <= '0;
        else if (!run_i)    cnt_q <= '0;
        else if (edge_i)    cnt_q <= CNT_W'(1);
        else if (timeout_o) cnt_q <= '0;
        else                cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/mrd_classifier.sv
module mrd_classifier
    import mrd_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int TOL   = 2
) (
    input  logic [CNT_W-1:0]  count_i,
    input  logic [1:0]        rate_class_i,
    input  logic              os128_i,
    output logic [CODE_W-1:0] code_o,
    output logic              good_o
);
    logic [NUM_RATIOS-1:0] hit;
    logic                  in_range;
    logic                  legal;

    for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_window
        localparam logic [CNT_W-1:0] LO = CNT_W'(ratio_of(g) - TOL);
        localparam logic [CNT_W-1:0] HI = CNT_W'(ratio_of(g) + TOL);
        assign hit[g] = (count_i >= LO) && (count_i <= HI);
    end

    always_comb begin
        code_o   = CODE_NONE;
        in_range = 1'b0;
        for (int i = 0; i < NUM_RATIOS; i++) begin
            if (hit[i]) begin
                code_o   = CODE_W'(i);
                in_range = 1'b1;
            end
        end
    end

    always_comb begin
        legal = 1'b1;
        if ((rate_class_i != 2'd0) && (code_o >= CODE_FIRST_HIGH)) legal = 1'b0;
        if (os128_i && (code_o <= CODE_LAST_LOW))                  legal = 1'b0;
    end

    assign good_o = in_range && legal;
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
    import mrd_pkg::*;
#(
    parameter int INIT_CYCLES = 1024,
    parameter int TIMEOUT     = 1024,
    parameter int TOL         = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wclk_i,
    input  logic [1:0] rate_class_i,
    input  logic       os128_i,
    output logic [2:0] ratio_o,
    output logic       valid_o,
    output logic       err_o
);
    localparam int CNT_W  = $clog2(TIMEOUT + 1);
    localparam int INIT_W = $clog2(INIT_CYCLES + 1);
    localparam logic [INIT_W-1:0] INIT_LAST = INIT_W'(INIT_CYCLES - 1);

    det_state_e        state_q, state_d;
    logic              wedge;
    logic [CNT_W-1:0]  count;
    logic              timeout;
    logic [CODE_W-1:0] code;
    logic              good;
    logic [CODE_W-1:0] cand_q;
    logic              err_q;
    logic [INIT_W-1:0] init_cnt_q;
    logic              init_done;
    logic              measuring;

    mrd_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (wclk_i),
        .rise_o  (wedge)
    );

    mrd_period_counter #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (state_q != ST_INIT),
        .edge_i    (wedge),
        .count_o   (count),
        .timeout_o (timeout)
    );

    mrd_classifier #(.CNT_W(CNT_W), .TOL(TOL)) u_cls (
        .count_i      (count),
        .rate_class_i (rate_class_i),
        .os128_i      (os128_i),
        .code_o       (code),
        .good_o       (good)
    );

    assign init_done = (init_cnt_q == INIT_LAST);
    assign measuring = (state_q == ST_MEAS) || (state_q == ST_CONFIRM) ||
                       (state_q == ST_LOCK);

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_INIT;
        else         state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT: begin
                if (init_done) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (wedge) state_d = ST_MEAS;
            end
            ST_MEAS: begin
                if (wedge)        state_d = good ? ST_CONFIRM : ST_MEAS;
                else if (timeout) state_d = ST_WAIT;
            end
            ST_CONFIRM: begin
                if (wedge) begin
                    if (!good)              state_d = ST_MEAS;
                    else if (code == cand_q) state_d = ST_LOCK;
                    else                     state_d = ST_CONFIRM;
                end else if (timeout) begin
                    state_d = ST_WAIT;
                end
            end
            ST_LOCK: begin
                if (wedge) begin
                    if (!good)              state_d = ST_MEAS;
                    else if (code == cand_q) state_d = ST_LOCK;
                    else                     state_d = ST_CONFIRM;
                end else if (timeout) begin
                    state_d = ST_WAIT;
                end
            end
            default: state_d = ST_INIT;
        endcase
    end

    // Hold counter, candidate code and error flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            init_cnt_q <= '0;
            cand_q     <= CODE_NONE;
            err_q      <= 1'b0;
        end else if (state_q == ST_INIT) begin
            init_cnt_q <= init_cnt_q + INIT_W'(1);
            cand_q     <= CODE_NONE;
            err_q      <= 1'b0;
        end else begin
            if (measuring && wedge) begin
                err_q <= !good;
                if (good) cand_q <= code;
            end else if (timeout) begin
                err_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        valid_o = (state_q == ST_LOCK);
        ratio_o = valid_o ? cand_q : CODE_NONE;
        err_o   = err_q;
    end
endmodule

// File: rtl/mrd_checker.sv
module mrd_checker #(
    parameter int INIT_CYCLES = 1024
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [1:0] rate_class_i,
    input logic       os128_i,
    input logic [2:0] ratio_o,
    input logic       valid_o,
    input logic       err_o
);
    localparam int HW = $clog2(INIT_CYCLES + 1);
    localparam logic [HW-1:0] HOLD_MAX = HW'(INIT_CYCLES);

    logic [HW-1:0] since_rst_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     since_rst_q <= '0;
        else if (since_rst_q < HOLD_MAX) since_rst_q <= since_rst_q + HW'(1);
    end

    // R2: code 7 exactly when not locked, never 6
    a_r2_code_matches_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o == (ratio_o <= 3'd5));
    a_r2_no_code_six: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ratio_o != 3'd6);

    // R9: default outputs during the initialisation hold
    a_r9_init_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_rst_q < HOLD_MAX) |-> (!valid_o && !err_o && ratio_o == 3'd7));

    // R4: a fresh lock at a high rate class never reports 512x or 768x
    a_r4_high_rate_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(valid_o) && $past(rate_class_i) != 2'd0) |-> (ratio_o <= 3'd3));

    // R5: a fresh lock in 128x mode is above 256x
    a_r5_os128_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(valid_o) && $past(os128_i)) |-> (ratio_o >= 3'd3));

    // R11: lock and error are exclusive
    a_r11_valid_err_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(valid_o && err_o));

    // R6: a lock never appears with the code changing at the same time
    a_r6_stable_code_on_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && $past(valid_o)) |-> $stable(ratio_o));
endmodule

bind mclk_ratio_detect mrd_checker #(.INIT_CYCLES(INIT_CYCLES)) u_mrd_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rate_class_i (rate_class_i),
    .os128_i      (os128_i),
    .ratio_o      (ratio_o),
    .valid_o      (valid_o),
    .err_o        (err_o)
);

// File: tb/test_mclk_ratio_detect.sv
`timescale 1ns/1ps
module test_mclk_ratio_detect;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wclk = 1'b0;
    logic [1:0] rate_class = 2'd0;
    logic       os128 = 1'b0;
    logic [2:0] ratio;
    logic       valid;
    logic       err;

    int per = 0;
    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk; // 250 MHz

    mclk_ratio_detect i_mclk_ratio_detect (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .wclk_i       (wclk),
        .rate_class_i (rate_class),
        .os128_i      (os128),
        .ratio_o      (ratio),
        .valid_o      (valid),
        .err_o        (err)
    );

    // Word clock generator: a period change takes effect at a cycle boundary
    initial begin
        int p;
        forever begin
            p = per;
            if (p == 0) begin
                wclk = 1'b0;
                @(negedge clk);
            end else begin
                wclk = 1'b1;
                repeat (p / 2) @(negedge clk);
                wclk = 1'b0;
                repeat (p - p / 2) @(negedge clk);
            end
        end
    end

    function automatic int ratio_val(input int idx);
        case (idx)
            0: return 128;
            1: return 192;
            2: return 256;
            3: return 384;
            4: return 512;
            default: return 768;
        endcase
    endfunction

    // Expected code (R1/R3/R4/R5), 7 when the window is rejected
    function automatic int exp_code(input int n, input int cls, input bit os);
        int c;
        c = 7;
        for (int i = 0; i < 6; i++)
            if (n >= ratio_val(i) - 2 && n <= ratio_val(i) + 2) c = i;
        if (c != 7 && cls != 0 && c >= 4) c = 7;
        if (c != 7 && os && c <= 2) c = 7;
        return c;
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int exp_r, input bit exp_v, input bit exp_e);
        n_checks++;
        if (ratio !== 3'(exp_r) || valid !== exp_v || err !== exp_e) begin
            n_fail++;
            $display("FAIL %s: ratio=%0d valid=%0b err=%0b expected ratio=%0d valid=%0b err=%0b",
                     req, ratio, valid, err, exp_r, exp_v, exp_e);
        end
    endtask

    task automatic expect_steady(input string req, input int n, input int cls, input bit os);
        int c;
        c = exp_code(n, cls, os);
        if (c == 7) check(req, 7, 1'b0, 1'b1);
        else        check(req, c, 1'b1, 1'b0);
    endtask

    task automatic apply(input string req, input int n, input int cls, input bit os);
        rate_class = 2'(cls);
        os128 = os;
        per = n;
        wait_cyc(4 * n + 800);
        expect_steady(req, n, cls, os);
    endtask

    initial begin
        #(4 * 195000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: ratio=%0d valid=%0b err=%0b expected run to finish", ratio, valid, err);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int seed;
        int idx, off, n, cls;
        bit os;
        seed = 32'h5eed_1792;
        void'($urandom(seed));

        // R10: default state while reset is held
        per = 256;
        wait_cyc(5);
        check("R10 in reset", 7, 1'b0, 1'b0);
        rst_n = 1'b1;

        // R9: hold for 1024 cycles even with a running word clock
        wait_cyc(600);
        check("R9 mid hold", 7, 1'b0, 1'b0);
        wait_cyc(415);
        check("R9 end of hold", 7, 1'b0, 1'b0);
        wait_cyc(4 * 256 + 200);
        check("R1 256x lock after hold", 2, 1'b1, 1'b0);

        // R1: each ratio at the base rate class
        for (int i = 0; i < 6; i++) apply("R1 base class ratio", ratio_val(i), 0, 1'b0);

        // R1/R3: tolerance limits
        apply("R1 +2 tolerance", 258, 0, 1'b0);
        apply("R1 -2 tolerance", 382, 0, 1'b0);
        apply("R3 +3 out of range", 259, 0, 1'b0);
        apply("R3 -3 out of range", 509, 0, 1'b0);

        // R4: high rate classes
        apply("R4 96k 512 rejected", 512, 1, 1'b0);
        apply("R4 192k 768 rejected", 768, 2, 1'b0);
        apply("R4 192k 384 accepted", 384, 2, 1'b0);
        apply("R4 class3 512 rejected", 512, 3, 1'b0);

        // R5: 128x modulator mode
        apply("R5 os128 256 rejected", 256, 0, 1'b1);
        apply("R5 os128 384 accepted", 384, 0, 1'b1);

        // R11: accepted window clears error after a rejection
        apply("R3 reject before recovery", 300, 0, 1'b0);
        apply("R11 error cleared", 192, 0, 1'b0);

        // R8: missing word clock
        per = 0;
        wait_cyc(2500);
        check("R8 word clock lost", 7, 1'b0, 1'b1);

        // R6: one accepted window is not enough
        per = 256;
        wait_cyc(256 + 100);
        check("R6 single window no lock", 7, 1'b0, 1'b0);
        wait_cyc(2 * 256 + 100);
        check("R6 two matching windows lock", 2, 1'b1, 1'b0);

        // R7: a mismatching window drops the lock at once
        per = 384;
        wait_cyc(256 + 384 + 10);
        check("R7 mismatch drops lock", 7, 1'b0, 1'b0);
        wait_cyc(384 + 200);
        check("R7 relock on new ratio", 3, 1'b1, 1'b0);

        // R10: external reset during lock restarts the hold
        rst_n = 1'b0;
        wait_cyc(3);
        check("R10 reset during lock", 7, 1'b0, 1'b0);
        rst_n = 1'b1;
        wait_cyc(1000);
        check("R10 hold restarted", 7, 1'b0, 1'b0);
        wait_cyc(4 * 384 + 300);
        check("R10 relock after reset", 3, 1'b1, 1'b0);

        // Constrained random sweep
        for (int k = 0; k < 16; k++) begin
            idx = int'($urandom_range(5, 0));
            off = int'($urandom_range(6, 0)) - 3;
            n = ratio_val(idx) + off;
            cls = int'($urandom_range(3, 0));
            os = ($urandom_range(3, 0) == 0);
            apply("R1 R3 R4 R5 random", n, cls, os);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule